// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver Slice

This block is a narrow two-way register slice that sits between a shared cutoff bus and local logic. Its transmit register captures the local word and drives it onto the bus. Its receive register captures the word coming in from the bus side and presents it on the receive outputs. Each register has its own load/hold control. When a register holds, its stored word is fed back into it, so the value stays put across clock edges. Data is never inverted.

The bus drive is gated by an enable flip-flop. In normal operation that flip-flop takes a synchronous enable on each clock edge. An asynchronous disable input turns the bus off at once, for example when the chip enters test. An active-low set input overrides the flip-flop. That set either allows a synchronous re-enable or gives purely asynchronous control through the disable line. A bus bit drives logic 1 only when the bus is enabled and the stored bit is 1. In every other case the bit floats, which models a cutoff driver.

In scan mode both registers form one serial shift chain. The chain starts at the serial input and ends at the top receive output bit, so no extra pin is needed for scan-out.

Top module: `scan_bus_transceiver`

## Requirements
- R1: With scanMode low and txLoad high, a rising clock edge stores aIn into the transmit register unchanged (bit i to bit i).
- R2: With scanMode low and txLoad low, the transmit register keeps its value across the clock edge, whatever aIn is.
- R3: With scanMode low and rxLoad high, a rising clock edge stores bIn into the receive register, which drives rxOut unchanged (bit i to bit i).
- R4: With scanMode low and rxLoad low, rxOut keeps its value across the clock edge, whatever bIn is.
- R5: With syncSetN high, busDisableAsync low and scanMode low, the bus enable flip-flop takes busEnableSync on each rising edge. Bus bit i is driven to 1 only when the bus is enabled and transmit bit i is 1. Otherwise bus bit i is high impedance.
- R6: Raising busDisableAsync releases every bus bit at once, with no clock edge needed.
- R7: With syncSetN high, the bus stays released after busDisableAsync falls. It re-enables only on a rising edge with busEnableSync high.
- R8: While syncSetN is low, the enable flip-flop is forced set and ignores busEnableSync and the clock. The bus is then enabled exactly while busDisableAsync is low.
- R9: With scanMode high, each rising edge shifts the chain scanIn → tx[0] → … → tx[WIDTH-1] → rx[0] → … → rx[WIDTH-1]. txLoad and rxLoad are ignored, and the enable flip-flop holds its value.
- R10: rxOut[WIDTH-1] is the scan output. After loading tx and rx and then applying 2·WIDTH scan shifts, it shows rx[WIDTH-2] down to rx[0], then tx[WIDTH-1] down to tx[0], then the first scanned-in bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| txLoad | input | 1 | Transmit load (1) or hold (0) |
| rxLoad | input | 1 | Receive load (1) or hold (0) |
| scanMode | input | 1 | 1 selects serial shift mode |
| scanIn | input | 1 | Serial scan data input |
| busDisableAsync | input | 1 | Asynchronous bus disable, active high |
| busEnableSync | input | 1 | Synchronous bus enable, sampled in normal mode |
| syncSetN | input | 1 | Active-low overriding set of the bus enable flip-flop |
| aIn | input | WIDTH | Transmit data in |
| bIn | input | WIDTH | Receive data in |
| busOut | output | WIDTH | Cutoff bus drive: 1 or high impedance |
| rxOut | output | WIDTH | Receive register; top bit doubles as scan out |

## Verification
The bench aims at the bus enable corners. It raises the disable between clock edges and checks the bus before the next edge; a design that waited for a clock would still drive the bus there. It releases the disable with the synchronous enable both low and high; a design that re-enabled on release alone would drive the bus too early. It pulls the active-low set down while the synchronous enable is low; a design without the override would keep the bus off. A directed scan of known words reads the top receive bit after every shift, which exposes a wrong chain order or a chain that skips a register. Random mixes of hold and load on each side catch a hold path that lets new data leak through.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic txLoad;
    logic rxLoad;
    logic shift;
    logic busEnable;
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         clk,
  input  logic         txLoadReq,
  input  logic         rxLoadReq,
  input  logic         scanMode,
  input  logic         busDisableAsync,
  input  logic         busEnableSync,
  input  logic         syncSetN,
  output xcvr_strobe_t strobes
);
  logic enableFlop;

  // set dominates clear; clear dominates the synchronous capture
  always_ff @(posedge clk or negedge syncSetN or posedge busDisableAsync) begin
    if (!syncSetN)            enableFlop <= 1'b1;
    else if (busDisableAsync) enableFlop <= 1'b0;
    else if (!scanMode)       enableFlop <= busEnableSync;
  end

  always_comb begin
    strobes.shift     = scanMode;
    strobes.txLoad    = txLoadReq & ~scanMode;
    strobes.rxLoad    = rxLoadReq & ~scanMode;
    strobes.busEnable = enableFlop & ~busDisableAsync;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  xcvr_strobe_t     strobes,
  input  logic             scanIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] txState,
  output logic [WIDTH-1:0] rxState
);
  localparam int CHAIN = 2 * WIDTH;

  logic [CHAIN-1:0] chainNow;
  logic [CHAIN-1:0] chainShifted;
  logic [WIDTH-1:0] txNext;
  logic [WIDTH-1:0] rxNext;

  assign chainNow     = {rxState, txState};
  assign chainShifted = {chainNow[CHAIN-2:0], scanIn};

  always_comb begin
    if (strobes.shift)       txNext = chainShifted[WIDTH-1:0];
    else if (strobes.txLoad) txNext = aIn;
    else                     txNext = txState;

    if (strobes.shift)       rxNext = chainShifted[CHAIN-1:WIDTH];
    else if (strobes.rxLoad) rxNext = bIn;
    else                     rxNext = rxState;
  end

  always_ff @(posedge clk) begin
    txState <= txNext;
    rxState <= rxNext;
  end
endmodule

// File: rtl/xcvr_busdrv.sv
module xcvr_busdrv #(
  parameter int WIDTH = 3
) (
  input  logic             busEnable,
  input  logic [WIDTH-1:0] txState,
  output logic [WIDTH-1:0] busOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign busOut[i] = (busEnable && txState[i]) ? 1'b1 : 1'bz;
  end
endmodule

// File: rtl/scan_bus_transceiver.sv
module scan_bus_transceiver
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             txLoad,
  input  logic             rxLoad,
  input  logic             scanMode,
  input  logic             scanIn,
  input  logic             busDisableAsync,
  input  logic             busEnableSync,
  input  logic             syncSetN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] rxOut
);
  xcvr_strobe_t     strobes;
  logic [WIDTH-1:0] txState;

  xcvr_ctrl u_ctrl (
    .clk             (clk),
    .txLoadReq       (txLoad),
    .rxLoadReq       (rxLoad),
    .scanMode        (scanMode),
    .busDisableAsync (busDisableAsync),
    .busEnableSync   (busEnableSync),
    .syncSetN        (syncSetN),
    .strobes         (strobes)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .scanIn  (scanIn),
    .aIn     (aIn),
    .bIn     (bIn),
    .txState (txState),
    .rxState (rxOut)
  );

  xcvr_busdrv #(.WIDTH(WIDTH)) u_drv (
    .busEnable (strobes.busEnable),
    .txState   (txState),
    .busOut    (busOut)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 3
) (
  input logic             clk,
  input logic             txLoad,
  input logic             rxLoad,
  input logic             scanMode,
  input logic             busDisableAsync,
  input logic             syncSetN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] busOut,
  input logic [WIDTH-1:0] rxOut,
  input logic [WIDTH-1:0] txState
);
  logic             armed = 1'b0;
  logic [WIDTH-1:0] busHigh;

  always_ff @(posedge clk) armed <= 1'b1;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) busHigh[i] = (busOut[i] === 1'b1);
  end

  // R1
  tx_load_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(!scanMode && txLoad) |-> txState == $past(aIn));
  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(!scanMode && !txLoad) |-> txState == $past(txState));
  // R3
  rx_load_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(!scanMode && rxLoad) |-> rxOut == $past(bIn));
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(!scanMode && !rxLoad) |-> rxOut == $past(rxOut));
  // R6
  async_off_chk: assert property (@(negedge clk) disable iff (!armed)
    busDisableAsync |-> busHigh == '0);
  // R8
  set_on_chk: assert property (@(negedge clk) disable iff (!armed)
    (!syncSetN && !busDisableAsync) |-> busHigh == txState);
  // R9
  scan_shift_chk: assert property (@(posedge clk) disable iff (!armed)
    $past(scanMode) |-> rxOut[0] == $past(txState[WIDTH-1]));
endmodule

bind scan_bus_transceiver xcvr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk             (clk),
  .txLoad          (txLoad),
  .rxLoad          (rxLoad),
  .scanMode        (scanMode),
  .busDisableAsync (busDisableAsync),
  .syncSetN        (syncSetN),
  .aIn             (aIn),
  .bIn             (bIn),
  .busOut          (busOut),
  .rxOut           (rxOut),
  .txState         (txState)
);

// File: tb/tb_scan_bus_transceiver.sv
`timescale 1ns/1ps
module tb_scan_bus_transceiver;
  localparam int W = 3;

  logic clk = 1'b0;
  logic txLoad = 0, rxLoad = 0, scanMode = 0, scanIn = 0;
  logic dis = 1'b1, sbe = 0, setN = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  wire  [W-1:0] busOut;
  logic [W-1:0] rxOut;

  logic [W-1:0] mTx, mRx;
  logic mEn;
  int tests = 0, fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  scan_bus_transceiver #(.WIDTH(W)) dut (
    .clk(clk), .txLoad(txLoad), .rxLoad(rxLoad), .scanMode(scanMode),
    .scanIn(scanIn), .busDisableAsync(dis), .busEnableSync(sbe),
    .syncSetN(setN), .aIn(aIn), .bIn(bIn), .busOut(busOut), .rxOut(rxOut)
  );

  function automatic logic [W-1:0] busHigh();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (busOut[i] === 1'b1);
    return v;
  endfunction

  function automatic logic [W-1:0] expBus();
    return (mEn && !dis) ? mTx : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(busHigh() == expBus(), tag, busHigh(), expBus());
    chk(rxOut == mRx, tag, rxOut, mRx);
  endtask

  // one clock; inputs already set away from the edge, model updated after it
  task automatic step();
    logic [2*W-1:0] ch;
    @(posedge clk);
    if (scanMode) begin
      ch = {mRx, mTx};
      ch = {ch[2*W-2:0], scanIn};
      {mRx, mTx} = ch;
    end else begin
      if (txLoad) mTx = aIn;
      if (rxLoad) mRx = bIn;
      if (setN && !dis) mEn = sbe;
    end
    if (!setN) mEn = 1'b1;
    else if (dis) mEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic setDis(input logic v);
    dis = v;
    if (!setN) mEn = 1'b1;
    else if (v) mEn = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=%b expected=%b", 1'b0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    void'($urandom(32'h5eed_1234));
    mTx = '0; mRx = '0; mEn = 1'b0;
    @(negedge clk);
    // prime both registers with a known load, bus held off by the disable
    txLoad = 1; rxLoad = 1; aIn = '0; bIn = '0;
    step();
    chk(busHigh() == '0, "R6 reset bus off", busHigh(), '0);
    chk(rxOut == '0, "R3 reset rx", rxOut, '0);

    // R1 R5: load tx, enable synchronously
    setDis(0);
    aIn = 3'b101; bIn = 3'b011; sbe = 1;
    step();
    checkAll("R1 tx load / R3 rx load");
    chk(busHigh() == 3'b101, "R5 bus drives ones", busHigh(), 3'b101);

    // R2 R4: hold both sides with new inputs present
    txLoad = 0; rxLoad = 0; aIn = 3'b010; bIn = 3'b100;
    step();
    chk(busHigh() == 3'b101, "R2 tx hold", busHigh(), 3'b101);
    chk(rxOut == 3'b011, "R4 rx hold", rxOut, 3'b011);

    // R5: synchronous disable via busEnableSync
    sbe = 0;
    step();
    chk(busHigh() == '0, "R5 sync disable", busHigh(), '0);
    sbe = 1;
    step();
    chk(busHigh() == 3'b101, "R5 sync re-enable", busHigh(), 3'b101);

    // R6: async disable mid-cycle, no edge
    #1 setDis(1);
    chk(busHigh() == '0, "R6 immediate disable", busHigh(), '0);
    @(negedge clk);
    // R7: release with sbe low stays off, then edge with sbe high enables
    sbe = 0;
    setDis(0);
    chk(busHigh() == '0, "R7 off after release", busHigh(), '0);
    step();
    chk(busHigh() == '0, "R7 off with sbe low", busHigh(), '0);
    sbe = 1;
    step();
    chk(busHigh() == 3'b101, "R7 re-enable on edge", busHigh(), 3'b101);

    // R8: override set while sbe low
    sbe = 0;
    setN = 0; mEn = 1'b1; #1;
    chk(busHigh() == 3'b101, "R8 set forces enable", busHigh(), 3'b101);
    step();
    chk(busHigh() == 3'b101, "R8 sbe ignored", busHigh(), 3'b101);
    setDis(1);
    chk(busHigh() == '0, "R8 disable still gates", busHigh(), '0);
    setDis(0);
    chk(busHigh() == 3'b101, "R8 async re-enable", busHigh(), 3'b101);
    sbe = 1; setN = 1; #1;
    step();

    // R9 R10: known words, then 2W scan shifts reading the top bit
    txLoad = 1; rxLoad = 1; aIn = 3'b110; bIn = 3'b001;
    step();
    begin
      logic [W-1:0] tx0, rx0;
      logic [2*W-1:0] pat;
      logic [2*W-1:0] expSeq;
      tx0 = 3'b110; rx0 = 3'b001; pat = 6'b101101;
      // top bit after shift k=1..6: rx1, rx0, tx2, tx1, tx0, first scanned bit
      expSeq = {rx0[1], rx0[0], tx0[2], tx0[1], tx0[0], pat[0]};
      scanMode = 1; txLoad = 1; rxLoad = 1; sbe = 0;
      for (int k = 0; k < 2*W; k++) begin
        scanIn = pat[k];
        step();
        chk(rxOut[W-1] == expSeq[2*W-1-k], "R10 scan out sequence", {2'b00, rxOut[W-1]}, {2'b00, expSeq[2*W-1-k]});
        checkAll("R9 scan shift");
      end
      chk(busHigh() == mTx, "R9 enable held in scan", busHigh(), mTx);
      scanMode = 0;
    end

    // random mix
    sbe = 1;
    for (int n = 0; n < 400; n++) begin
      txLoad = $urandom % 2; rxLoad = $urandom % 2;
      scanMode = ($urandom % 8) == 0; scanIn = $urandom % 2;
      sbe = ($urandom % 4) != 0;
      aIn = $urandom; bIn = $urandom;
      if (($urandom % 10) == 0) setDis(~dis);
      step();
      checkAll(scanMode ? "R9 random scan" : "R5 random normal");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule